// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of interrupt sources and presents one request at a time to a processor. Some sources are wired hardware lines. The lowest-numbered few are flags that software sets and clears through write strobes. Each source has a four-bit level, where 0 switches the source off. The controller offers the pending, enabled source with the highest level, together with a 9-bit vector equal to the source index. When two or more pending sources share the top level, the one with the smallest index wins.

A running-priority register holds the level of the code currently executing. A source is offered only when its level is strictly above that value. Software can write the register directly, for example to raise it to a ceiling around a shared resource. The processor takes the offered request with an acknowledge strobe. That strobe saves the running priority on a last-in, first-out stack and raises it to the level of the source being serviced. An end-of-service strobe pops the saved value back, so handlers can nest. A critical-interrupt input does not pass through the arbitration; it is forwarded to its output unchanged. A configurable range of source indices is reserved and can never be offered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req_o` is 0, `irq_vec_o` is 0 and `cur_prio_o` is 0. Every source level is 0 and the save stack is empty.
- R2: A hardware line at index i (input bit i−NUM_SW) that is high, with a level above the running priority, drives `irq_req_o` high and `irq_vec_o` to i. This happens on the second rising edge after the line rises. Level writes and software flag changes take effect with the same two-edge latency.
- R3: A source whose level is 0 is never offered, even when it is pending.
- R4: Among the eligible pending sources, the one with the highest level is offered.
- R5: Among eligible pending sources of equal level, the one with the lowest index is offered.
- R6: A source is offered only when its level is strictly greater than `cur_prio_o`. A level equal to the running priority is masked.
- R7: `cpr_we_i` loads `cpr_val_i` into `cur_prio_o` at the next rising edge. The offered request is re-evaluated against the new value in that same edge.
- R8: `sw_set_i[j]` sets the pending flag of source j (j < NUM_SW), and `sw_clr_i[j]` clears it. If both are high in one cycle, the set wins.
- R9: `ack_i`, while `irq_req_o` is high and the stack is not full, does three things. It pushes `cur_prio_o`, loads the offered source's level into `cur_prio_o` at the next edge, and drops a request that is no longer above it in that same edge.
- R10: `eoi_i` with a non-empty stack pops the most recently saved level into `cur_prio_o` at the next edge. With an empty stack it has no effect.
- R11: `ack_i` has no effect when the stack already holds STACK_DEPTH entries or when `irq_req_o` is low.
- R12: Sources with index from RSV_LO to RSV_HI are never offered. Level writes to them, or to indices at or beyond NUM_SRC, are ignored.
- R13: `crit_o` follows `crit_i` combinationally.
- R14: Within one cycle, `ack_i` takes precedence over `eoi_i`, and `eoi_i` over `cpr_we_i`. The strobe of lower precedence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hw_irq_i | input | NUM_SRC-NUM_SW | Hardware request lines, bit k is source NUM_SW+k |
| sw_set_i | input | NUM_SW | Set strobes for software sources |
| sw_clr_i | input | NUM_SW | Clear strobes for software sources |
| lvl_we_i | input | 1 | Write strobe for a source level |
| lvl_idx_i | input | 9 | Source index for the level write |
| lvl_val_i | input | 4 | Level value to write |
| cpr_we_i | input | 1 | Write strobe for the running priority |
| cpr_val_i | input | 4 | New running priority |
| ack_i | input | 1 | Processor takes the offered request |
| eoi_i | input | 1 | Processor finishes the current handler |
| crit_i | input | 1 | Critical interrupt input |
| irq_req_o | output | 1 | A request is offered |
| irq_vec_o | output | 9 | Vector of the offered request |
| cur_prio_o | output | 4 | Running priority |
| crit_o | output | 1 | Critical interrupt forwarded |

## Verification
The hardest state to reach from the ports is a completely full save stack while a request is still being offered. Only then can the dropped acknowledge be observed. The stimulus builds this state one step at a time. It acknowledges a software source, then enables another source one level higher, and repeats until STACK_DEPTH entries are held. It then offers one more source and shows that the running priority holds still under acknowledge. Finally it unwinds the stack with end-of-service strobes, checking each restored level, and issues one extra strobe on the empty stack.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 9;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic  valid;
        vec_t  vec;
        prio_t prio;
    } offer_t;

    typedef enum logic [1:0] {
        CUR_HOLD,
        CUR_ACK,
        CUR_EOI,
        CUR_WRITE
    } cur_op_e;

    function automatic logic in_reserved(input int idx, input int lo, input int hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SW  = 8,
    localparam int NUM_HW = NUM_SRC - NUM_SW
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_HW-1:0]  hw_irq_i,
    input  logic [NUM_SW-1:0]  sw_set_i,
    input  logic [NUM_SW-1:0]  sw_clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        always_ff @(posedge clk_i) begin
            if (rst_i)
                pend_o[s] <= 1'b0;
            else if (sw_set_i[s])
                pend_o[s] <= 1'b1;
            else if (sw_clr_i[s])
                pend_o[s] <= 1'b0;
        end
    end

    for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
        always_ff @(posedge clk_i) begin
            if (rst_i)
                pend_o[NUM_SW+h] <= 1'b0;
            else
                pend_o[NUM_SW+h] <= hw_irq_i[h];
        end
    end

endmodule

// File: rtl/irq_level_table.sv
module irq_level_table
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int RSV_LO  = 28,
    parameter int RSV_HI  = 29
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     we_i,
    input  vec_t                     idx_i,
    input  prio_t                    val_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_o
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
        if (in_reserved(s, RSV_LO, RSV_HI)) begin : g_rsv
            assign lvl_o[s] = '0;
        end else begin : g_reg
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    lvl_o[s] <= '0;
                else if (we_i && (idx_i == vec_t'(s)))
                    lvl_o[s] <= val_i;
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int RSV_LO  = 28,
    parameter int RSV_HI  = 29
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_i,
    input  prio_t                          floor_i,
    output offer_t                         win_o
);

    logic [NUM_SRC-1:0] elig;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
        if (in_reserved(s, RSV_LO, RSV_HI)) begin : g_rsv
            assign elig[s] = 1'b0;
        end else begin : g_src
            assign elig[s] = pend_i[s] && (lvl_i[s] > floor_i);
        end
    end

    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        win_o = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (elig[s] && (!win_o.valid || lvl_i[s] >= win_o.prio)) begin
                win_o.valid = 1'b1;
                win_o.vec   = vec_t'(s);
                win_o.prio  = lvl_i[s];
            end
        end
    end

endmodule

// File: rtl/irq_prio_lifo.sv
module irq_prio_lifo
    import irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  prio_t            din_i,
    output prio_t            top_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             empty_o
);

    prio_t            mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign full_o  = (cnt_o == CNT_W'(DEPTH));
    assign empty_o = (cnt_o == '0);
    assign wr_idx  = IDX_W'(cnt_o);
    assign rd_idx  = IDX_W'(cnt_o - CNT_W'(1));
    assign top_o   = empty_o ? '0 : mem[rd_idx];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= '0;
        end else if (push_i && !full_o) begin
            mem[wr_idx] <= din_i;
            cnt_o       <= cnt_o + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            cnt_o <= cnt_o - CNT_W'(1);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int NUM_SW      = 8,
    parameter int RSV_LO      = 28,
    parameter int RSV_HI      = 29,
    parameter int STACK_DEPTH = 4,
    localparam int NUM_HW = NUM_SRC - NUM_SW,
    localparam int CNT_W  = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_HW-1:0] hw_irq_i,
    input  logic [NUM_SW-1:0] sw_set_i,
    input  logic [NUM_SW-1:0] sw_clr_i,
    input  logic              lvl_we_i,
    input  logic [8:0]        lvl_idx_i,
    input  logic [3:0]        lvl_val_i,
    input  logic              cpr_we_i,
    input  logic [3:0]        cpr_val_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              crit_i,
    output logic              irq_req_o,
    output logic [8:0]        irq_vec_o,
    output logic [3:0]        cur_prio_o,
    output logic              crit_o
);

    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0][PRIO_W-1:0] lvl;
    offer_t                         win;
    offer_t                         offer_q;
    prio_t                          cur_q;
    prio_t                          cur_nxt;
    prio_t                          lifo_top;
    logic [CNT_W-1:0]               lifo_cnt;
    logic                           lifo_full;
    logic                           lifo_empty;
    cur_op_e                        op;

    irq_pending #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) u_pend (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hw_irq_i (hw_irq_i),
        .sw_set_i (sw_set_i),
        .sw_clr_i (sw_clr_i),
        .pend_o   (pend)
    );

    irq_level_table #(.NUM_SRC(NUM_SRC), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_lvl (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (lvl_we_i),
        .idx_i (lvl_idx_i),
        .val_i (lvl_val_i),
        .lvl_o (lvl)
    );

    // precedence: acknowledge, then end of service, then direct write
    always_comb begin
        op = CUR_HOLD;
        if (ack_i) begin
            if (offer_q.valid && !lifo_full)
                op = CUR_ACK;
        end else if (eoi_i) begin
            if (!lifo_empty)
                op = CUR_EOI;
        end else if (cpr_we_i) begin
            op = CUR_WRITE;
        end
    end

    always_comb begin
        unique case (op)
            CUR_ACK:   cur_nxt = offer_q.prio;
            CUR_EOI:   cur_nxt = lifo_top;
            CUR_WRITE: cur_nxt = cpr_val_i;
            default:   cur_nxt = cur_q;
        endcase
    end

    irq_prio_lifo #(.DEPTH(STACK_DEPTH)) u_lifo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (op == CUR_ACK),
        .pop_i   (op == CUR_EOI),
        .din_i   (cur_q),
        .top_o   (lifo_top),
        .cnt_o   (lifo_cnt),
        .full_o  (lifo_full),
        .empty_o (lifo_empty)
    );

    // compare against the next running priority so the offer never lags it
    irq_arbiter #(.NUM_SRC(NUM_SRC), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_arb (
        .pend_i  (pend),
        .lvl_i   (lvl),
        .floor_i (cur_nxt),
        .win_o   (win)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q   <= '0;
            offer_q <= '0;
        end else begin
            cur_q   <= cur_nxt;
            offer_q <= win;
        end
    end

    assign irq_req_o  = offer_q.valid;
    assign irq_vec_o  = offer_q.vec;
    assign cur_prio_o = cur_q;
    assign crit_o     = crit_i;

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
    parameter int STACK_DEPTH = 4,
    parameter int RSV_LO      = 28,
    parameter int RSV_HI      = 29,
    localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             ack_i,
    input logic             eoi_i,
    input logic             irq_req_o,
    input logic [8:0]       irq_vec_o,
    input logic [3:0]       cur_prio_o,
    input logic [3:0]       offer_prio,
    input logic [CNT_W-1:0] depth
);

    p_req_above_cur_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_req_o |-> (offer_prio > cur_prio_o));

    p_ack_raise_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && irq_req_o && depth < CNT_W'(STACK_DEPTH)) |=>
            (cur_prio_o == $past(offer_prio)) && (depth == $past(depth) + CNT_W'(1)));

    p_eoi_pop_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ack_i && eoi_i && depth != '0) |=> (depth == $past(depth) - CNT_W'(1)));

    p_eoi_empty_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ack_i && eoi_i && depth == '0) |=> $stable(cur_prio_o) && $stable(depth));

    p_ack_full_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && depth == CNT_W'(STACK_DEPTH)) |=> $stable(cur_prio_o) && $stable(depth));

    p_ack_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && !irq_req_o) |=> $stable(cur_prio_o) && $stable(depth));

    p_no_reserved_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_req_o |-> (int'(irq_vec_o) < RSV_LO || int'(irq_vec_o) > RSV_HI));

    always @(posedge clk_i) begin
        if (!rst_i) begin
            p_depth_bound_r11: assert (depth <= CNT_W'(STACK_DEPTH));
        end
    end

endmodule

bind prio_irq_ctrl irq_ctrl_checker #(
    .STACK_DEPTH (STACK_DEPTH),
    .RSV_LO      (RSV_LO),
    .RSV_HI      (RSV_HI)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ack_i      (ack_i),
    .eoi_i      (eoi_i),
    .irq_req_o  (irq_req_o),
    .irq_vec_o  (irq_vec_o),
    .cur_prio_o (cur_prio_o),
    .offer_prio (offer_q.prio),
    .depth      (lifo_cnt)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    localparam int NUM_SRC = 32;
    localparam int NUM_SW  = 8;
    localparam int NUM_HW  = NUM_SRC - NUM_SW;
    localparam int DEPTH   = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [NUM_HW-1:0] hw_irq;
    logic [NUM_SW-1:0] sw_set, sw_clr;
    logic              lvl_we;
    logic [8:0]        lvl_idx;
    logic [3:0]        lvl_val;
    logic              cpr_we;
    logic [3:0]        cpr_val;
    logic              ack, eoi, crit;
    logic              irq_req;
    logic [8:0]        irq_vec;
    logic [3:0]        cur_prio;
    logic              crit_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .RSV_LO(28), .RSV_HI(29),
                    .STACK_DEPTH(DEPTH)) u0 (
        .clk_i(clk), .rst_i(rst), .hw_irq_i(hw_irq), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
        .lvl_we_i(lvl_we), .lvl_idx_i(lvl_idx), .lvl_val_i(lvl_val),
        .cpr_we_i(cpr_we), .cpr_val_i(cpr_val), .ack_i(ack), .eoi_i(eoi),
        .crit_i(crit), .irq_req_o(irq_req), .irq_vec_o(irq_vec),
        .cur_prio_o(cur_prio), .crit_o(crit_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance n rising edges, return at the falling edge after the last
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; hw_irq = '0; sw_set = '0; sw_clr = '0;
        lvl_we = 1'b0; lvl_idx = '0; lvl_val = '0;
        cpr_we = 1'b0; cpr_val = '0; ack = 1'b0; eoi = 1'b0; crit = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input int val);
        lvl_we = 1'b1; lvl_idx = 9'(idx); lvl_val = 4'(val);
        step(1);
        lvl_we = 1'b0;
    endtask

    task automatic hw(input int idx, input logic v);
        hw_irq[idx-NUM_SW] = v;
    endtask

    task automatic sw_pulse(input int idx, input logic set, input logic clr);
        sw_set[idx] = set; sw_clr[idx] = clr;
        step(1);
        sw_set = '0; sw_clr = '0;
    endtask

    task automatic strobe_ack(); ack = 1'b1; step(1); ack = 1'b0; endtask
    task automatic strobe_eoi(); eoi = 1'b1; step(1); eoi = 1'b0; endtask
    task automatic write_cpr(input int v);
        cpr_we = 1'b1; cpr_val = 4'(v); step(1); cpr_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 req", irq_req, 0);
        check("R1 vec", irq_vec, 0);
        check("R1 cur", cur_prio, 0);
    endtask

    task automatic t_basic();
        do_reset();
        set_lvl(10, 3);
        hw(10, 1'b1);
        step(1);
        check("R2 latency one edge", irq_req, 0);
        step(1);
        check("R2 req", irq_req, 1);
        check("R2 vec", irq_vec, 10);
        hw(10, 1'b0);
        step(2);
        check("R2 line low", irq_req, 0);
    endtask

    task automatic t_disabled();
        do_reset();
        hw(12, 1'b1);
        step(3);
        check("R3 level zero", irq_req, 0);
    endtask

    task automatic t_order();
        do_reset();
        set_lvl(10, 3); set_lvl(20, 7);
        hw(10, 1'b1); hw(20, 1'b1);
        step(2);
        check("R4 highest level", irq_vec, 20);
        set_lvl(15, 7);
        hw(15, 1'b1);
        step(2);
        check("R5 lowest index tie", irq_vec, 15);
        write_cpr(7);
        check("R7 cur written", cur_prio, 7);
        check("R6 equal level masked", irq_req, 0);
        write_cpr(6);
        check("R6 above cur", irq_req, 1);
        check("R6 vec", irq_vec, 15);
    endtask

    task automatic t_software();
        do_reset();
        set_lvl(3, 9);
        sw_pulse(3, 1'b1, 1'b0);
        step(1);
        check("R8 set", irq_vec, 3);
        check("R8 set req", irq_req, 1);
        sw_pulse(3, 1'b0, 1'b1);
        step(1);
        check("R8 clear", irq_req, 0);
        sw_pulse(3, 1'b1, 1'b1);
        step(1);
        check("R8 set wins", irq_req, 1);
    endtask

    task automatic t_nesting();
        do_reset();
        set_lvl(0, 4); set_lvl(1, 8);
        sw_pulse(0, 1'b1, 1'b0);
        step(1);
        check("R9 first offer", irq_vec, 0);
        strobe_ack();
        check("R9 cur raised", cur_prio, 4);
        check("R9 request dropped", irq_req, 0);
        sw_pulse(1, 1'b1, 1'b0);
        step(1);
        check("R9 nested offer", irq_vec, 1);
        strobe_ack();
        check("R9 nested cur", cur_prio, 8);
        strobe_eoi();
        check("R10 pop", cur_prio, 4);
        check("R10 reoffer", irq_req, 1);
        strobe_eoi();
        check("R10 pop base", cur_prio, 0);
        strobe_eoi();
        check("R10 empty ignored", cur_prio, 0);
        sw_pulse(0, 1'b0, 1'b1);
        sw_pulse(1, 1'b0, 1'b1);
        step(1);
        check("R11 idle", irq_req, 0);
        strobe_ack();
        check("R11 ack without request", cur_prio, 0);
        strobe_eoi();
        check("R11 nothing pushed", cur_prio, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            set_lvl(k, k + 1);
            sw_pulse(k, 1'b1, 1'b0);
            step(1);
            strobe_ack();
        end
        check("R9 filled cur", cur_prio, DEPTH);
        set_lvl(DEPTH, DEPTH + 1);
        sw_pulse(DEPTH, 1'b1, 1'b0);
        step(1);
        check("R11 offer while full", irq_req, 1);
        strobe_ack();
        check("R11 full ack ignored cur", cur_prio, DEPTH);
        check("R11 full ack keeps req", irq_req, 1);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            strobe_eoi();
            check("R10 unwind", cur_prio, k);
        end
        strobe_eoi();
        check("R10 extra eoi", cur_prio, 0);
    endtask

    task automatic t_reserved();
        do_reset();
        set_lvl(28, 9);
        set_lvl(40, 9);
        set_lvl(27, 2);
        hw(28, 1'b1); hw(29, 1'b1); hw(27, 1'b1);
        step(2);
        check("R12 reserved skipped", irq_vec, 27);
        check("R12 req", irq_req, 1);
        write_cpr(2);
        check("R12 reserved stays off", irq_req, 0);
    endtask

    task automatic t_crit();
        do_reset();
        crit = 1'b1; #1;
        check("R13 high", crit_out, 1);
        crit = 1'b0; #1;
        check("R13 low", crit_out, 0);
    endtask

    task automatic t_precedence();
        do_reset();
        write_cpr(2);
        set_lvl(0, 5); set_lvl(1, 9);
        sw_pulse(0, 1'b1, 1'b0);
        step(1);
        strobe_ack();
        check("R14 setup", cur_prio, 5);
        sw_pulse(1, 1'b1, 1'b0);
        step(1);
        ack = 1'b1; eoi = 1'b1; cpr_we = 1'b1; cpr_val = 4'd1;
        step(1);
        ack = 1'b0; eoi = 1'b0; cpr_we = 1'b0;
        check("R14 ack wins", cur_prio, 9);
        strobe_eoi();
        check("R14 pop one", cur_prio, 5);
        eoi = 1'b1; cpr_we = 1'b1; cpr_val = 4'd7;
        step(1);
        eoi = 1'b0; cpr_we = 1'b0;
        check("R14 eoi over write", cur_prio, 2);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_basic();
        t_disabled();
        t_order();
        t_software();
        t_nesting();
        t_full();
        t_reserved();
        t_crit();
        t_precedence();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule